// File: doc/BRIEF.md
# Stopwatch Run/Clear Controller

This block pairs a small state machine with the elapsed-time counter it governs. Two level-sensitive push-button inputs feed it. One asks the timer to run and the other asks it to clear. Each clock, the state machine picks one of three states from the buttons. The state is decoded into two mutually exclusive strobes, a count enable and a force-to-zero. The counter beside it uses those strobes to advance, hold or reset the elapsed tick value.

The clear button always outranks the run button, so pressing both resets the timer instead of advancing it. The states are STOPPED, RUNNING and CLEARING. From any state the transitions are the same: GO_CLEAR (clear pressed) leads to CLEARING, GO_RUN (run pressed, clear released) leads to RUNNING, and GO_STOP (both released) leads to STOPPED. The strobes are decoded from the registered state, so a button change reaches the strobes one clock after it is sampled and reaches the counter value one clock after that.

Top module: `stopwatch_core`

## Requirements
- R1: A synchronous active-high reset gives state STOPPED, both strobes 0 and elapsed value 0 after the next clock edge.
- R2: If clear is 1 at a clock edge, the state becomes CLEARING and the zero strobe is 1 after that edge, whatever the run input is.
- R3: If run is 1 and clear is 0 at a clock edge, the state becomes RUNNING and the enable strobe is 1 after that edge.
- R4: If both buttons are 0 at a clock edge, the state becomes STOPPED and both strobes are 0 after that edge.
- R5: The enable and zero strobes are never 1 in the same cycle.
- R6: At each clock edge where the enable strobe is 1, the elapsed value increases by exactly one.
- R7: At each clock edge where the zero strobe is 1, the elapsed value becomes 0.
- R8: At each clock edge where both strobes are 0, the elapsed value keeps its value.
- R9: The elapsed value is WIDTH bits wide and an increment from its all-ones value gives 0.
- R10: If clear is released while run stays held, the first edge after the release leaves the elapsed value at 0 with enable 1, and the edge after that gives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_run | input | 1 | Run button level, 1 = run |
| btn_clear | input | 1 | Clear button level, 1 = clear |
| cnt_en | output | 1 | Count enable strobe, 1 in RUNNING |
| cnt_zero | output | 1 | Force-to-zero strobe, 1 in CLEARING |
| elapsed | output | WIDTH | Elapsed tick count |

## Verification
A wrong state shows up on the strobes one clock after the buttons that caused it. It shows up in the elapsed value one clock later as a missed reset, an extra increment or a stalled count. The bench therefore compares both strobes and the count at every cycle against a model that uses only the priority rule. It steps through all button pairs from each of the three states. The count is 4 bits wide, so wrap-around and the clear-then-run handoff are reached within a few dozen cycles.

// File: rtl/stopwatch_pkg.sv
package stopwatch_pkg;

    typedef enum logic [1:0] {
        SW_STOPPED  = 2'd0,
        SW_RUNNING  = 2'd1,
        SW_CLEARING = 2'd2
    } sw_state_e;

    typedef struct packed {
        logic en;
        logic zero;
    } sw_strobe_t;

endpackage

// File: rtl/stopwatch_fsm.sv
module stopwatch_fsm
    import stopwatch_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_run,
    input  logic       btn_clear,
    output sw_strobe_t strobe
);

    sw_state_e state_q;
    sw_state_e state_d;

    // Transition selection: clear outranks run in every state.
    always_comb begin
        unique case (state_q)
            SW_STOPPED,
            SW_RUNNING,
            SW_CLEARING: begin
                if (btn_clear)    state_d = SW_CLEARING;   // GO_CLEAR
                else if (btn_run) state_d = SW_RUNNING;    // GO_RUN
                else              state_d = SW_STOPPED;    // GO_STOP
            end
            default:              state_d = SW_STOPPED;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SW_STOPPED;
        else     state_q <= state_d;
    end

    // Moore output decode
    always_comb begin
        strobe = '0;
        unique case (state_q)
            SW_STOPPED:  strobe = '0;
            SW_RUNNING:  strobe.en   = 1'b1;
            SW_CLEARING: strobe.zero = 1'b1;
            default:     strobe = '0;
        endcase
    end

endmodule

// File: rtl/stopwatch_counter.sv
module stopwatch_counter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             zero,
    output logic [WIDTH-1:0] value
);

    localparam logic [WIDTH-1:0] STEP = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] value_q;

    // Zero has priority; natural modulo-2^WIDTH wrap on increment.
    always_ff @(posedge clk) begin
        if (rst || zero) value_q <= '0;
        else if (en)     value_q <= value_q + STEP;
    end

    assign value = value_q;

endmodule

// File: rtl/stopwatch_core.sv
module stopwatch_core
    import stopwatch_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             btn_run,
    input  logic             btn_clear,
    output logic             cnt_en,
    output logic             cnt_zero,
    output logic [WIDTH-1:0] elapsed
);

    sw_strobe_t strobe;

    stopwatch_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .btn_run   (btn_run),
        .btn_clear (btn_clear),
        .strobe    (strobe)
    );

    stopwatch_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .en    (strobe.en),
        .zero  (strobe.zero),
        .value (elapsed)
    );

    assign cnt_en   = strobe.en;
    assign cnt_zero = strobe.zero;

endmodule

// File: rtl/stopwatch_checker.sv
module stopwatch_checker #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             btn_run,
    input logic             btn_clear,
    input logic             cnt_en,
    input logic             cnt_zero,
    input logic [WIDTH-1:0] elapsed
);

    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!cnt_en && !cnt_zero && elapsed == '0)); // R1
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(btn_clear)) |-> (cnt_zero && !cnt_en)); // R2
    AST_RUN_ENTER: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(btn_run) && !$past(btn_clear)) |-> cnt_en); // R3
    AST_STOP_ENTER: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && !$past(btn_run) && !$past(btn_clear)) |-> (!cnt_en && !cnt_zero)); // R4
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) !(cnt_en && cnt_zero)); // R5
    AST_COUNT_UP: assert property (@(posedge clk) disable iff (rst) cnt_en |=> (elapsed == $past(elapsed) + ONE)); // R6
    AST_ZERO_APPLY: assert property (@(posedge clk) disable iff (rst) cnt_zero |=> (elapsed == '0)); // R7
    AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (rst) (!cnt_en && !cnt_zero) |=> $stable(elapsed)); // R8

endmodule

bind stopwatch_core stopwatch_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .btn_run   (btn_run),
    .btn_clear (btn_clear),
    .cnt_en    (cnt_en),
    .cnt_zero  (cnt_zero),
    .elapsed   (elapsed)
);

// File: tb/sim_stopwatch_core.sv
`timescale 1ns/1ps
module sim_stopwatch_core;

    localparam int W    = 4;
    localparam int MODV = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         btn_run = 1'b0;
    logic         btn_clear = 1'b0;
    logic         cnt_en;
    logic         cnt_zero;
    logic [W-1:0] elapsed;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model: 0 stopped, 1 running, 2 clearing
    int m_st  = 0;
    int m_cnt = 0;

    always #2.5 clk = ~clk;

    stopwatch_core #(.WIDTH(W)) u0 (
        .clk       (clk),
        .rst       (rst),
        .btn_run   (btn_run),
        .btn_clear (btn_clear),
        .cnt_en    (cnt_en),
        .cnt_zero  (cnt_zero),
        .elapsed   (elapsed)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Apply buttons, clock once, advance model, compare at negedge.
    task automatic tick(input logic r, input logic c);
        string ctag;
        btn_run   = r;
        btn_clear = c;
        @(posedge clk);
        if (m_st == 1)      begin m_cnt = (m_cnt + 1) % MODV; ctag = "R6 count"; end
        else if (m_st == 2) begin m_cnt = 0;                  ctag = "R7 zero";  end
        else                begin                             ctag = "R8 hold";  end
        m_st = c ? 2 : (r ? 1 : 0);
        @(negedge clk);
        if (m_st == 2)      chk("R2 clear strobe", int'(cnt_zero), 1);
        else if (m_st == 1) chk("R3 run enable",  int'(cnt_en), 1);
        else                chk("R4 stopped idle", int'(cnt_en | cnt_zero), 0);
        chk("R5 exclusive strobes", int'(cnt_en & cnt_zero), 0);
        chk(ctag, int'(elapsed), m_cnt);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        btn_run = 1'b0;
        btn_clear = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_st = 0;
        m_cnt = 0;
        chk("R1 reset enable", int'(cnt_en), 0);
        chk("R1 reset zero", int'(cnt_zero), 0);
        chk("R1 reset elapsed", int'(elapsed), 0);
    endtask

    initial begin
        logic [7:0] lfsr;
        @(negedge clk);
        do_reset();

        // run for a while, then both pressed: clear must win (R2)
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
        tick(1'b1, 1'b1);
        tick(1'b1, 1'b1);
        chk("R2 both pressed clears", int'(elapsed), 0);

        // release clear with run held (R10)
        tick(1'b1, 1'b0);
        chk("R10 first cycle after release", int'(elapsed), 0);
        chk("R10 enable after release", int'(cnt_en), 1);
        tick(1'b1, 1'b0);
        chk("R10 resumes from zero", int'(elapsed), 1);

        // wrap (R9): run until count returns to zero
        for (int i = 0; i < MODV - 1; i++) tick(1'b1, 1'b0);
        chk("R9 wrap to zero", int'(elapsed), 0);
        tick(1'b0, 1'b0);
        chk("R9 one after wrap", int'(elapsed), 1);

        // exhaustive: every state times every button pair
        for (int s = 0; s < 3; s++) begin
            for (int p = 0; p < 4; p++) begin
                tick(s == 1, s == 2);
                tick(p[0], p[1]);
                tick(1'b0, 1'b0);
            end
        end

        // reset while running (R1)
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b0);
        do_reset();

        // pseudo-random sweep
        lfsr = 8'hA5;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            tick(lfsr[0] | lfsr[1], lfsr[2] & lfsr[3] & lfsr[4]);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule